// File: doc/BRIEF.md
# Precision-Scalable Fused Sub-Word Multiplier

This block multiplies small integers with one shared array of four 4x4-bit sub-multipliers. A run-time mode input decides how the array is used. In fused mode the four sub-products are weighted by nibble position and added into one 8x8-bit product. In split mode every sub-multiplier works alone on its own nibble pair, giving four 4x4-bit products in the same cycle. The same fused path serves 8-bit integer operands and unsigned 8-bit floating-point significands, so no multiplier is built twice for different precisions.

A signedness input picks two's complement or unsigned interpretation for the transaction. Each transaction is taken on a valid/ready handshake and its result appears on a registered output one cycle later, with a valid flag. The result bus is 32 bits wide so that it can carry four 8-bit lane products side by side. A fused product uses only the low 16 bits.

Top module: `subword_mul_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0, `out_data` is all zeros and `in_ready` is 0. From the first edge with `rst_n` high, `in_ready` is 1.
- R2: A transaction is accepted at an edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 in the cycle after each accepted transaction, and it is 0 after any edge with no acceptance.
- R3: With `mode` = 1 (fused) and `is_signed` = 0, `out_data[15:0]` equals the unsigned product `op_a[7:0] * op_b[7:0]`, and `out_data[31:16]` is zero.
- R4: With `mode` = 1 and `is_signed` = 1, `out_data[15:0]` equals the 16-bit two's-complement product of `op_a[7:0]` and `op_b[7:0]`, both read as signed, and `out_data[31:16]` is zero.
- R5: With `mode` = 0 (split) and `is_signed` = 0, for each lane k from 0 to 3, `out_data[8k+7:8k]` equals the unsigned product of `op_a[4k+3:4k]` and `op_b[4k+3:4k]`.
- R6: With `mode` = 0 and `is_signed` = 1, each lane's byte `out_data[8k+7:8k]` equals the 8-bit two's-complement product of the two signed nibbles `op_a[4k+3:4k]` and `op_b[4k+3:4k]`. This includes -8 x -8 = 64.
- R7: In fused mode, `op_a[15:8]` and `op_b[15:8]` have no effect on the result.
- R8: After an edge with no acceptance, `out_data` keeps the value it had before that edge.
- R9: Mode and signedness are sampled with each transaction. Back-to-back transactions that change mode or signedness every cycle each give the result of their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are offered |
| in_ready | output | 1 | Block can take a transaction |
| mode | input | 1 | 1 = one fused 8x8 product, 0 = four split 4x4 products |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| op_a | input | 16 | Multiplicand: four nibbles in split mode, low byte in fused mode |
| op_b | input | 16 | Multiplier: four nibbles in split mode, low byte in fused mode |
| out_data | output | 32 | Registered result: lane k in bits [8k+7:8k], or a fused product in [15:0] |
| out_valid | output | 1 | out_data holds the result of the transaction accepted one cycle earlier |

## Verification
A wrong sign flag on a sub-multiplier, or a wrong nibble-weight shift, gives a wrong `out_data` in the cycle right after the transaction is accepted. It shows up only for operand patterns that touch that nibble: a negative upper nibble for a sign error, a nonzero partial product for a shift error. The corner operands (0, -8, 7, -128, 127, 255) and a mixed random sweep are chosen so that every lane and every sign combination is exercised in both modes. A wrong operand routing or a stale mode would show when modes alternate on consecutive cycles. A broken enable on the output register would show as `out_data` moving during idle cycles.

// File: rtl/sw_mul_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the sub-word multiplier.
// Assumes a 2x2 nibble arrangement: four sub-multiplier lanes.
package sw_mul_pkg;

    // Run-time configuration of the sub-multiplier array
    typedef enum logic {
        MODE_SPLIT = 1'b0,
        MODE_FUSED = 1'b1
    } sw_mode_e;

    // Number of sub-multiplier lanes (fixed by the 2x2 fusing scheme)
    localparam int LANES = 4;

    // In fused mode: 1 when lane k takes the upper nibble of operand A
    function automatic int lane_a_hi(int k);
        return (k >> 1) & 1;
    endfunction

    // In fused mode: 1 when lane k takes the upper nibble of operand B
    function automatic int lane_b_hi(int k);
        return k & 1;
    endfunction

    // Left shift applied to lane k's product when the lanes are fused
    function automatic int fuse_shift(int k, int nib_w);
        return (lane_a_hi(k) + lane_b_hi(k)) * nib_w;
    endfunction

endpackage

// File: rtl/sw_mul_lane.sv
`timescale 1ns/1ps
// One sub-multiplier lane: NIB_W x NIB_W -> 2*NIB_W product.
// Each operand carries its own signedness flag, so an unsigned lower
// nibble can be multiplied by a signed upper nibble. The product is
// returned modulo 2^(2*NIB_W). Any sign/unsigned mix fits in that width.
// Purely combinational.
module sw_mul_lane #(
    parameter  int NIB_W  = 4,
    localparam int PROD_W = 2 * NIB_W,
    localparam int EXT_W  = 2 * NIB_W + 2
) (
    input  logic [NIB_W-1:0]  a,
    input  logic              a_sgn,
    input  logic [NIB_W-1:0]  b,
    input  logic              b_sgn,
    output logic [PROD_W-1:0] p
);

    logic signed [NIB_W:0] a_ext;
    logic signed [NIB_W:0] b_ext;
    logic signed [EXT_W-1:0] full;

    // Extend each operand by one bit according to its own flag, then multiply
    always_comb begin
        a_ext = {a_sgn & a[NIB_W-1], a};
        b_ext = {b_sgn & b[NIB_W-1], b};
        full  = EXT_W'(a_ext) * EXT_W'(b_ext);
        p     = full[PROD_W-1:0];
    end

    // The dropped high bits must be pure sign (or zero) extension of p (R5, R6)
    always_comb begin
        if (!$isunknown({a, b, a_sgn, b_sgn})) begin
            if (a_sgn | b_sgn) begin
                p_lane_fits_r6: assert (full[EXT_W-1:PROD_W-1] == '0 ||
                                        full[EXT_W-1:PROD_W-1] == '1)
                    else $error("signed lane product overflows");
            end else begin
                p_lane_fits_r5: assert (full[EXT_W-1:PROD_W] == '0)
                    else $error("unsigned lane product overflows");
            end
        end
    end

endmodule

// File: rtl/sw_mul_fuse.sv
`timescale 1ns/1ps
// Combines the lane products. In fused mode each product is sign- or
// zero-extended by its flag, shifted by its nibble weight and summed
// into one 4*NIB_W-bit product. In split mode the lane products are
// packed side by side, lane k in bits [k*2*NIB_W +: 2*NIB_W].
// Purely combinational; assumes four lanes.
module sw_mul_fuse
    import sw_mul_pkg::*;
#(
    parameter  int NIB_W  = 4,
    localparam int PROD_W = 2 * NIB_W,
    localparam int WIDE_W = 4 * NIB_W,
    localparam int RES_W  = LANES * PROD_W
) (
    input  sw_mode_e                       mode,
    input  logic [LANES-1:0][PROD_W-1:0]   pp,
    input  logic [LANES-1:0]               pp_sgn,
    output logic [RES_W-1:0]               res
);

    logic [LANES-1:0][WIDE_W-1:0] term;
    logic [WIDE_W-1:0]            fused_sum;

    // Weight each lane product by the position of its nibble pair
    for (genvar k = 0; k < LANES; k++) begin : g_term
        assign term[k] = {{(WIDE_W-PROD_W){pp_sgn[k] & pp[k][PROD_W-1]}}, pp[k]}
                         << fuse_shift(k, NIB_W);
    end

    // Add the weighted terms modulo 2^WIDE_W
    always_comb begin
        fused_sum = '0;
        for (int k = 0; k < LANES; k++) begin
            fused_sum = fused_sum + term[k];
        end
    end

    // Choose the fused sum or the packed lane products
    always_comb begin
        if (mode == MODE_FUSED) begin
            res = {{(RES_W-WIDE_W){1'b0}}, fused_sum};
        end else begin
            res = pp;
        end
    end

endmodule

// File: rtl/subword_mul_top.sv
`timescale 1ns/1ps
// Precision-scalable multiplier built from four NIB_W x NIB_W lanes.
// Fused mode: one (2*NIB_W) x (2*NIB_W) product from the low halves of
// op_a/op_b. Split mode: four independent nibble products.
// A transaction is taken on in_valid & in_ready. The result is registered
// once and out_valid follows acceptance by one cycle. No output back-pressure.
module subword_mul_top
    import sw_mul_pkg::*;
#(
    parameter  int NIB_W  = 4,
    localparam int OP_W   = LANES * NIB_W,
    localparam int PROD_W = 2 * NIB_W,
    localparam int RES_W  = LANES * PROD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             mode,
    input  logic             is_signed,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [RES_W-1:0] out_data,
    output logic             out_valid
);

    sw_mode_e                     mode_e;
    logic                         accept;
    logic [LANES-1:0][PROD_W-1:0] lane_p;
    logic [LANES-1:0]             lane_sgn;
    logic [RES_W-1:0]             comb_res;

    assign mode_e = sw_mode_e'(mode);
    assign accept = in_valid & in_ready;

    // Route operands and sign flags to each lane, then multiply
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int AH = lane_a_hi(k);
        localparam int BH = lane_b_hi(k);

        logic [NIB_W-1:0] a_nib;
        logic [NIB_W-1:0] b_nib;
        logic             a_sgn;
        logic             b_sgn;

        // Fused: pick nibble by weight, sign only on upper nibbles; split: own nibble
        always_comb begin
            if (mode_e == MODE_FUSED) begin
                a_nib = op_a[AH*NIB_W +: NIB_W];
                b_nib = op_b[BH*NIB_W +: NIB_W];
                a_sgn = (AH == 1) ? is_signed : 1'b0;
                b_sgn = (BH == 1) ? is_signed : 1'b0;
            end else begin
                a_nib = op_a[k*NIB_W +: NIB_W];
                b_nib = op_b[k*NIB_W +: NIB_W];
                a_sgn = is_signed;
                b_sgn = is_signed;
            end
        end

        assign lane_sgn[k] = a_sgn | b_sgn;

        sw_mul_lane #(.NIB_W(NIB_W)) u_lane (
            .a     (a_nib),
            .a_sgn (a_sgn),
            .b     (b_nib),
            .b_sgn (b_sgn),
            .p     (lane_p[k])
        );
    end

    sw_mul_fuse #(.NIB_W(NIB_W)) u_fuse (
        .mode   (mode_e),
        .pp     (lane_p),
        .pp_sgn (lane_sgn),
        .res    (comb_res)
    );

    // Output register and ready flag; result is loaded only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ready  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            in_ready  <= 1'b1;
            out_valid <= accept;
            if (accept) begin
                out_data <= comb_res;
            end
        end
    end

    // R2: each acceptance is reported one cycle later
    p_valid_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid)
        else $error("accepted transaction not reported");

    // R2: no acceptance, no valid
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid)
        else $error("out_valid without acceptance");

    // R8: result holds while nothing is accepted
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(out_data))
        else $error("out_data moved without acceptance");

    // R3: a fused result leaves the upper lanes clear
    p_fused_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_e == MODE_FUSED) |=> (out_data[RES_W-1:4*NIB_W] == '0))
        else $error("fused result has upper bits set");

endmodule

// File: tb/subword_mul_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module subword_mul_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic        mode;
    logic        is_signed;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic [31:0] out_data;
    logic        out_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    subword_mul_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .mode      (mode),
        .is_signed (is_signed),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Behavioural product from the requirements (mode 1 = fused)
    function automatic logic [31:0] model(bit m, bit s, logic [15:0] a, logic [15:0] b);
        logic [31:0] r;
        r = '0;
        if (m) begin
            if (s) begin
                logic signed [15:0] p;
                p = $signed(a[7:0]) * $signed(b[7:0]);
                r[15:0] = p;
            end else begin
                r[15:0] = a[7:0] * b[7:0];
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (s) begin
                    logic signed [7:0] q;
                    q = $signed(a[4*k +: 4]) * $signed(b[4*k +: 4]);
                    r[8*k +: 8] = q;
                end else begin
                    r[8*k +: 8] = a[4*k +: 4] * b[4*k +: 4];
                end
            end
        end
        return r;
    endfunction

    // Offer one transaction at a falling edge, check it at the next one
    task automatic run_op(string req, bit m, bit s, logic [15:0] a, logic [15:0] b);
        in_valid  = 1'b1;
        mode      = m;
        is_signed = s;
        op_a      = a;
        op_b      = b;
        @(negedge clk);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(req, out_data, model(m, s, a, b));
    endtask

    task automatic go_idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // R1: reset state and ready release
    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        mode = 1'b1; is_signed = 1'b0; op_a = 16'hFFFF; op_b = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 data in reset", out_data, 32'd0);
        chk("R1 ready in reset", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, in_ready}, 32'd1);
        chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    endtask

    // R3: fused unsigned, including 255 x 255 significand case
    task automatic t_fused_unsigned();
        run_op("R3 255x255", 1, 0, 16'h00FF, 16'h00FF);
        run_op("R3 0x255",   1, 0, 16'h0000, 16'h00FF);
        run_op("R3 127x255", 1, 0, 16'h007F, 16'h00FF);
        run_op("R3 128x129", 1, 0, 16'h0080, 16'h0081);
        run_op("R3 mixed",   1, 0, 16'h00A7, 16'h005C);
        go_idle();
    endtask

    // R4: fused signed corners
    task automatic t_fused_signed();
        run_op("R4 -128x-128", 1, 1, 16'h0080, 16'h0080);
        run_op("R4 -128x127",  1, 1, 16'h0080, 16'h007F);
        run_op("R4 127x127",   1, 1, 16'h007F, 16'h007F);
        run_op("R4 -1x-1",     1, 1, 16'h00FF, 16'h00FF);
        run_op("R4 0x-128",    1, 1, 16'h0000, 16'h0080);
        run_op("R4 -93x45",    1, 1, 16'h00A3, 16'h002D);
        go_idle();
    endtask

    // R5: split unsigned lanes
    task automatic t_split_unsigned();
        run_op("R5 all 15x15", 0, 0, 16'hFFFF, 16'hFFFF);
        run_op("R5 zeros",     0, 0, 16'h0F0F, 16'hF0F0);
        run_op("R5 mixed",     0, 0, 16'h7F80, 16'h8F17);
        go_idle();
    endtask

    // R6: split signed lanes: -8x-8, -8x7, 7x7, 0
    task automatic t_split_signed();
        run_op("R6 corners", 0, 1, 16'h0788, 16'h1778);
        run_op("R6 all -8",  0, 1, 16'h8888, 16'h8888);
        run_op("R6 -1 lanes", 0, 1, 16'hF3F5, 16'hFFA9);
        go_idle();
    endtask

    // R7: upper operand bytes ignored in fused mode
    task automatic t_upper_ignored();
        run_op("R7 junk upper u", 1, 0, 16'hA5C3, 16'h5A3C);
        run_op("R7 junk upper s", 1, 1, 16'hFF80, 16'h0F7F);
        run_op("R7 junk upper s2", 1, 1, 16'h1280, 16'h8080);
        go_idle();
    endtask

    // R8, R2: output holds and valid drops while idle
    task automatic t_hold();
        logic [31:0] kept;
        run_op("R8 load", 1, 0, 16'h00C8, 16'h00B3);
        kept     = model(1, 0, 16'h00C8, 16'h00B3);
        in_valid = 1'b0;
        mode = 1'b0; is_signed = 1'b1; op_a = 16'h8888; op_b = 16'h7777;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 no valid when idle", {31'd0, out_valid}, 32'd0);
            chk("R8 hold when idle", out_data, kept);
        end
    endtask

    // R9, R2: alternating mode and signedness back to back
    task automatic t_mode_switch();
        run_op("R9 fused s",  1, 1, 16'h3C81, 16'h99F7);
        run_op("R9 split u",  0, 0, 16'h3C81, 16'h99F7);
        run_op("R9 fused u",  1, 0, 16'h3C81, 16'h99F7);
        run_op("R9 split s",  0, 1, 16'h3C81, 16'h99F7);
        run_op("R9 fused s2", 1, 1, 16'h0088, 16'h0077);
        go_idle();
    endtask

    // R3 R4 R5 R6: random sweep over all mode and sign combinations
    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            bit m;
            bit s;
            m = i[0];
            s = i[1];
            run_op(m ? (s ? "R4 random" : "R3 random") : (s ? "R6 random" : "R5 random"),
                   m, s, 16'($urandom), 16'($urandom));
        end
        go_idle();
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0; is_signed = 1'b0;
        op_a = '0; op_b = '0;
        @(negedge clk);
        t_reset();
        t_fused_unsigned();
        t_fused_signed();
        t_split_unsigned();
        t_split_signed();
        t_upper_ignored();
        t_hold();
        t_mode_switch();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule